// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Bank

This block holds one software-interrupt pending bit per hart and exposes it to a simple memory-mapped request port. A hart raises an inter-processor interrupt on a peer by writing a word with bit 0 set into that peer's slot. Each pending bit drives one interrupt output toward its hart.

The parameter `SUPERVISOR_MODE` chooses one of two behaviours.

- **Machine flavour (`SUPERVISOR_MODE = 0`):** the slot behaves as a level register. Writing 1 sets the bit, writing 0 clears it, and reads return the bit.
- **Supervisor flavour (`SUPERVISOR_MODE = 1`):** the slot can only be set from the bus and always reads zero. The bit is dropped from the hart side through a per-hart clear input.

Every request is sorted into one of four access kinds, using an enumerated decode:

- `ACC_IDLE`: no request.
- `ACC_READ`: a valid read.
- `ACC_WRITE`: a valid write.
- `ACC_REJECT`: a misaligned, out-of-range or wrongly sized access.

The pending cells and the read register act on that kind. No access kind ever causes a transition to another kind: each cycle is decoded on its own.

Top module: `swi_bank`

## Requirements
- R1: Hart `h` owns the word at byte offset `4*h`. An access is valid only when the offset has bits [1:0] equal to 0 and is below `NUM_HARTS*4`.
- R2: Only word accesses are accepted. A request is valid only with `bus_size` = 2'b10, where 2'b00 means byte, 2'b01 half-word and 2'b11 double-word; any other size is rejected.
- R3: A valid write with `bus_wdata[0]` = 1 sets that hart's pending bit. `sw_irq[h]` is 1 from the cycle after the write edge.
- R4: In machine flavour, a valid write with `bus_wdata[0]` = 0 clears the pending bit. In supervisor flavour, such a write leaves the bit unchanged.
- R5: A valid read returns the pending bit in bit 0 of `bus_rdata`, in the cycle after the request, in machine flavour. In supervisor flavour, `bus_rdata` is always zero.
- R6: Reset clears every pending bit, so every `sw_irq` line is 0 and `bus_rdata` is 0.
- R7: A rejected access is discarded. A rejected read returns zero and a rejected write changes no pending bit.
- R8: In supervisor flavour, `hart_clear[h]` clears pending bit `h`, but a same-cycle valid set of `h` wins. In machine flavour, `hart_clear` is ignored.
- R9: Bits [31:1] of `bus_wdata` are ignored, and bits [31:1] of `bus_rdata` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the bank |
| bus_size | input | 2 | Access size code (2'b10 = word) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| hart_clear | input | NUM_HARTS | Per-hart clear from the hart side (supervisor flavour) |
| sw_irq | output | NUM_HARTS | Per-hart software interrupt lines |

## Verification
Both flavours are instantiated side by side and driven with the same requests, so a single stimulus shows where the two flavours differ on writes of 0, on reads and on `hart_clear`.

Directed cases exercise the following:

- **Sizes and offsets:** each rejected size, a misaligned offset and the first offset past the bank. These separate the address and size decode from the pending logic.
- **Upper data bits:** a write of 0xFFFF_FFFE, which shows whether bits above bit 0 are ignored.
- **Set against clear:** a set and a clear to the same hart in the same cycle, which decides the priority.

Random requests, with offsets spanning both valid and invalid addresses and with random clear vectors, then check the interplay of all of these against a bench model.

// File: rtl/swi_bank_pkg.sv
package swi_bank_pkg;

    // Size code for a 32-bit access on the request port.
    localparam logic [1:0] SIZE_WORD = 2'b10;

    // Classification of one request cycle.
    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_READ   = 2'd1,
        ACC_WRITE  = 2'd2,
        ACC_REJECT = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/swi_addr_decode.sv
module swi_addr_decode
    import swi_bank_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 12,
    parameter int IDX_W     = 2
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  hart_idx,
    output logic [NUM_HARTS-1:0] wr_onehot
);
    localparam logic [31:0] SPAN = 32'(NUM_HARTS * 4);

    logic in_span;
    logic aligned;
    logic size_ok;

    assign in_span  = 32'(req_addr) < SPAN;
    assign aligned  = req_addr[1:0] == 2'b00;
    assign size_ok  = req_size == SIZE_WORD;
    assign hart_idx = req_addr[IDX_W+1:2];

    always_comb begin
        if (!req_valid) begin
            kind = ACC_IDLE;
        end else if (!(in_span && aligned && size_ok)) begin
            kind = ACC_REJECT;
        end else if (req_write) begin
            kind = ACC_WRITE;
        end else begin
            kind = ACC_READ;
        end
    end

    always_comb begin
        wr_onehot = '0;
        unique case (kind)
            ACC_WRITE: wr_onehot[hart_idx] = 1'b1;
            ACC_IDLE, ACC_READ, ACC_REJECT: wr_onehot = '0;
        endcase
    end

    // At most one hart is addressed by a write.
    always_comb begin
        assert_single_target_R1: assert ($onehot0(wr_onehot));
    end

endmodule

// File: rtl/swi_pending_cell.sv
module swi_pending_cell #(
    parameter bit SUPERVISOR_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic set_val,
    input  logic clr_req,
    output logic pend
);
    logic pend_d;

    generate
        if (SUPERVISOR_MODE) begin : g_sup
            always_comb begin
                if (wr_hit && set_val) begin
                    pend_d = 1'b1;
                end else if (clr_req) begin
                    pend_d = 1'b0;
                end else begin
                    pend_d = pend;
                end
            end
        end else begin : g_mach
            always_comb begin
                pend_d = wr_hit ? set_val : pend;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            pend <= pend_d;
        end
    end

    assert_set_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && set_val) |=> pend);

    assert_mach_write_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!SUPERVISOR_MODE && wr_hit && !set_val) |=> !pend);

    assert_sup_write_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (SUPERVISOR_MODE && !(wr_hit && set_val) && !clr_req) |=> $stable(pend));

    assert_sup_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (SUPERVISOR_MODE && clr_req && !(wr_hit && set_val)) |=> !pend);

    assert_mach_clear_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!SUPERVISOR_MODE && !wr_hit) |=> $stable(pend));

endmodule

// File: rtl/swi_read_path.sv
module swi_read_path
    import swi_bank_pkg::*;
#(
    parameter int NUM_HARTS       = 4,
    parameter int IDX_W           = 2,
    parameter bit SUPERVISOR_MODE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  acc_kind_e            kind,
    input  logic [IDX_W-1:0]     hart_idx,
    input  logic [NUM_HARTS-1:0] pend_vec,
    output logic [31:0]          rdata
);
    logic rbit_d;

    always_comb begin
        rbit_d = 1'b0;
        unique case (kind)
            ACC_READ:   rbit_d = SUPERVISOR_MODE ? 1'b0 : pend_vec[hart_idx];
            ACC_IDLE, ACC_WRITE, ACC_REJECT: rbit_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= {31'b0, rbit_d};
        end
    end

    assert_read_returns_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!SUPERVISOR_MODE && kind == ACC_READ) |=> rdata[0] == $past(pend_vec[hart_idx]));

    assert_reject_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_REJECT) |=> rdata == 32'd0);

endmodule

// File: rtl/swi_bank.sv
module swi_bank
    import swi_bank_pkg::*;
#(
    parameter int NUM_HARTS       = 4,
    parameter int ADDR_W          = 12,
    parameter bit SUPERVISOR_MODE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_HARTS-1:0] hart_clear,
    output logic [NUM_HARTS-1:0] sw_irq
);
    localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    acc_kind_e            kind;
    logic [IDX_W-1:0]     hart_idx;
    logic [NUM_HARTS-1:0] wr_onehot;
    logic [NUM_HARTS-1:0] pend_vec;

    swi_addr_decode #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W)
    ) u_decode (
        .req_valid (bus_valid),
        .req_write (bus_write),
        .req_addr  (bus_addr),
        .req_size  (bus_size),
        .kind      (kind),
        .hart_idx  (hart_idx),
        .wr_onehot (wr_onehot)
    );

    generate
        for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
            swi_pending_cell #(
                .SUPERVISOR_MODE (SUPERVISOR_MODE)
            ) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_hit  (wr_onehot[h]),
                .set_val (bus_wdata[0]),
                .clr_req (hart_clear[h]),
                .pend    (pend_vec[h])
            );
        end
    endgenerate

    swi_read_path #(
        .NUM_HARTS       (NUM_HARTS),
        .IDX_W           (IDX_W),
        .SUPERVISOR_MODE (SUPERVISOR_MODE)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .hart_idx (hart_idx),
        .pend_vec (pend_vec),
        .rdata    (bus_rdata)
    );

    assign sw_irq = pend_vec;

    assert_reject_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!SUPERVISOR_MODE && bus_valid && bus_write && kind == ACC_REJECT) |=> $stable(sw_irq));

    assert_upper_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:1] == 31'd0);

    assert_sup_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        SUPERVISOR_MODE |-> bus_rdata == 32'd0);

    assert_bad_size_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_size != SIZE_WORD) |-> kind == ACC_REJECT);

endmodule

// File: tb/test_swi_bank.sv
module test_swi_bank;
    localparam int NH = 4;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = 2'b10;
    logic [31:0]   bus_wdata = '0;
    logic [NH-1:0] hart_clear = '0;
    logic [31:0]   rdata_m, rdata_s;
    logic [NH-1:0] irq_m, irq_s;

    int checks = 0;
    int failures = 0;
    logic [NH-1:0] mod_m = '0;
    logic [NH-1:0] mod_s = '0;

    always #10 clk = ~clk;

    swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .SUPERVISOR_MODE(1'b0)) i_swi_bank (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_m), .hart_clear(hart_clear), .sw_irq(irq_m));

    swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .SUPERVISOR_MODE(1'b1)) i_swi_bank_sup (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_s), .hart_clear(hart_clear), .sw_irq(irq_s));

    function automatic logic acc_ok(input logic [AW-1:0] a, input logic [1:0] sz);
        return (sz == 2'b10) && (a[1:0] == 2'b00) && (32'(a) < 32'(NH * 4));
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge, step one cycle, compare at the next falling edge.
    task automatic op(input string req, input logic v, input logic wr, input logic [AW-1:0] a,
                      input logic [1:0] sz, input logic [31:0] d, input logic [NH-1:0] clr);
        logic ok;
        logic [31:0] exp_rd_m;
        bus_valid = v; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d; hart_clear = clr;
        ok = v && acc_ok(a, sz);
        exp_rd_m = (ok && !wr) ? {31'b0, mod_m[a[3:2]]} : 32'd0;
        if (ok && wr) mod_m[a[3:2]] = d[0];
        for (int h = 0; h < NH; h++) begin
            if (ok && wr && a[3:2] == h[1:0] && d[0]) mod_s[h] = 1'b1;
            else if (clr[h]) mod_s[h] = 1'b0;
        end
        @(negedge clk);
        check32({req, " mach rdata"}, rdata_m, exp_rd_m);
        check32({req, " sup rdata"}, rdata_s, 32'd0);
        check32({req, " mach irq"}, 32'(irq_m), 32'(mod_m));
        check32({req, " sup irq"}, 32'(irq_s), 32'(mod_s));
        bus_valid = 1'b0; hart_clear = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R6: reset state
        check32("R6 reset irq m", 32'(irq_m), 32'd0);
        check32("R6 reset irq s", 32'(irq_s), 32'd0);
        check32("R6 reset rdata", rdata_m, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R3: set each hart at its own offset
        for (int h = 0; h < NH; h++) op("R1 R3 set", 1, 1, AW'(h * 4), 2'b10, 32'd1, '0);
        // R5: read back every slot
        for (int h = 0; h < NH; h++) op("R5 read", 1, 0, AW'(h * 4), 2'b10, 32'd0, '0);
        // R4: write zero to hart 1
        op("R4 write zero", 1, 1, 12'h004, 2'b10, 32'd0, '0);
        op("R4 read after zero", 1, 0, 12'h004, 2'b10, 32'd0, '0);
        // R9: upper bits ignored
        op("R9 upper bits", 1, 1, 12'h008, 2'b10, 32'hFFFF_FFFE, '0);
        op("R9 read", 1, 0, 12'h008, 2'b10, 32'd0, '0);
        // R2: wrong sizes rejected
        op("R2 byte", 1, 1, 12'h004, 2'b00, 32'd1, '0);
        op("R2 half", 1, 1, 12'h004, 2'b01, 32'd1, '0);
        op("R2 dword", 1, 1, 12'h004, 2'b11, 32'd1, '0);
        op("R2 dword read", 1, 0, 12'h000, 2'b11, 32'd0, '0);
        // R7: misaligned and out of range
        op("R7 misaligned", 1, 1, 12'h005, 2'b10, 32'd1, '0);
        op("R7 past end", 1, 1, 12'h010, 2'b10, 32'd0, '0);
        op("R7 past end read", 1, 0, 12'h010, 2'b10, 32'd0, '0);
        op("R7 misaligned read", 1, 0, 12'h002, 2'b10, 32'd0, '0);
        // R8: clear from hart side, and set winning over clear
        op("R8 clear h0", 0, 0, 12'h000, 2'b10, 32'd0, 4'b0001);
        op("R8 set vs clear", 1, 1, 12'h00C, 2'b10, 32'd1, 4'b1000);
        op("R8 clear all", 0, 0, 12'h000, 2'b10, 32'd0, 4'b1111);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            logic [1:0] sz;
            a  = AW'($urandom % 22);
            sz = ($urandom % 4 == 0) ? 2'($urandom) : 2'b10;
            op("R1 R3 R4 R8 random", 1'($urandom % 5 != 0), 1'($urandom), a, sz,
               $urandom, NH'($urandom % 3 == 0 ? $urandom : 0));
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule